// File: doc/BRIEF.md
# Pattern-Filtered Baud-Rate Phase Detector

This block is the phase detector of a baud-rate clock recovery loop. Each accepted symbol brings one hard decision from the data slicer and one sign bit from the error slicer. The block keeps a three-symbol window made of the previous, current and next decisions. For four qualifying windows it compares the error sign of mirror-image pattern pairs and casts an early or a late vote. The votes steer the sampling instant toward the point where the pulse-response pre-cursor equals the post-cursor. Balancing the sliced level of 011 against 110, and of 100 against 001, keeps the detector from sliding to a false lock when an adaptive feedback equalizer drives the first post-cursor to zero.

Votes are summed over a block of 2^M evaluated windows, where M is set on `blk_log2`. At the end of each block the total is presented with a one-cycle done pulse, together with a single up or down pulse that follows the sign of the total. A downstream loop filter consumes these pulses. The symbol input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and a symbol is taken on every clock edge where `in_valid` is high.

Top module: `mm_pattern_pd`

## Requirements
- R1: The window for symbol k is (a(k-1), a(k), a(k+1)), written left to right as the pattern bits, with `in_data` = 1 meaning the +1 symbol. The window is paired with the error sign captured with symbol k. It is evaluated on the edge that accepts a(k+1), and its vote appears on `sym_early`/`sym_late` in the cycle after that edge.
- R2: With `in_err` = 1 meaning the sample lies above the reference, window 011 votes late for err 1 and early for err 0. Window 110 votes early for err 1 and late for err 0.
- R3: Window 100 votes early for err 1 and late for err 0. Window 001 votes late for err 1 and early for err 0.
- R4: Windows 000, 111, 010 and 101 produce no vote.
- R5: `sym_early` and `sym_late` are never high together, and `phase_up` and `phase_dn` are never high together.
- R6: A cycle with `in_valid` low changes neither the window history nor the block count, and it produces no vote. `in_ready` is always 1.
- R7: Every evaluated window, voting or not, counts toward a block of 2^M windows, with M = min(`blk_log2`, MAX_LOG2). `blk_done` pulses for one cycle, in the cycle after the last window of the block, and `blk_sum` then holds the two's-complement total, where early counts +1 and late counts -1.
- R8: With the done pulse, `phase_up` pulses if the total is positive and `phase_dn` pulses if it is negative. Neither pulses if the total is zero.
- R9: The vote of the last window of a block is included in that block's total, and it appears on `sym_early`/`sym_late` in the same cycle as `blk_done`. With M = 0, every window is a block of its own.
- R10: A synchronous reset clears the history, the fill state, the block count, the running total and all outputs. After reset, the first two accepted symbols produce no vote and no block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_log2 | input | LOG_W | Block length exponent M |
| in_valid | input | 1 | Symbol valid |
| in_ready | output | 1 | Always 1, no back-pressure |
| in_data | input | 1 | Data decision, 1 = +1 symbol |
| in_err | input | 1 | Error-slicer sign, 1 = above reference |
| sym_early | output | 1 | Per-window early vote |
| sym_late | output | 1 | Per-window late vote |
| blk_done | output | 1 | Block end pulse |
| blk_sum | output | SUM_W | Signed vote total of the last block |
| phase_up | output | 1 | Total positive at block end |
| phase_dn | output | 1 | Total negative at block end |

## Verification
Two events can land on the same edge: the per-window vote of the last symbol in a block, and the closing of that block. To provoke this, the bench runs blocks whose final window qualifies. It also uses M = 0, so that every voting window closes its own block. The bench checks that the vote pulse and the done pulse appear together, and that the reported total already includes that final vote, with the up or down pulse chosen from the total after that vote has been added.

// File: rtl/mm_pattern_pd_pkg.sv
package mm_pattern_pd_pkg;

  typedef enum logic [1:0] {
    VOTE_NONE  = 2'd0,
    VOTE_EARLY = 2'd1,
    VOTE_LATE  = 2'd2
  } vote_e;

  // qualifying decision windows, oldest symbol in the MSB
  localparam logic [2:0] WIN_RISE_HOLD = 3'b011;
  localparam logic [2:0] WIN_HOLD_FALL = 3'b110;
  localparam logic [2:0] WIN_FALL_HOLD = 3'b100;
  localparam logic [2:0] WIN_LOW_RISE  = 3'b001;

endpackage

// File: rtl/pd_window.sv
module pd_window (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       dec,
  input  logic       err,
  output logic [2:0] win,
  output logic       win_err,
  output logic       win_ok
);

  localparam logic [1:0] FILL_FULL = 2'd2;

  logic       dec_old;
  logic       dec_mid;
  logic       err_mid;
  logic [1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_old <= 1'b0;
      dec_mid <= 1'b0;
      err_mid <= 1'b0;
      fill    <= 2'd0;
    end else if (take) begin
      dec_old <= dec_mid;
      dec_mid <= dec;
      err_mid <= err;
      if (fill != FILL_FULL) fill <= fill + 2'd1;
    end
  end

  assign win     = {dec_old, dec_mid, dec};
  assign win_err = err_mid;
  assign win_ok  = take && (fill == FILL_FULL);

endmodule

// File: rtl/pd_pattern_vote.sv
module pd_pattern_vote
  import mm_pattern_pd_pkg::*;
(
  input  logic [2:0] win,
  input  logic       win_err,
  input  logic       win_ok,
  output vote_e      vote
);

  vote_e raw;

  always_comb begin
    unique case (win)
      WIN_RISE_HOLD: raw = win_err ? VOTE_LATE  : VOTE_EARLY;
      WIN_HOLD_FALL: raw = win_err ? VOTE_EARLY : VOTE_LATE;
      WIN_FALL_HOLD: raw = win_err ? VOTE_EARLY : VOTE_LATE;
      WIN_LOW_RISE:  raw = win_err ? VOTE_LATE  : VOTE_EARLY;
      default:       raw = VOTE_NONE;
    endcase
  end

  assign vote = win_ok ? raw : VOTE_NONE;

endmodule

// File: rtl/pd_block_acc.sv
module pd_block_acc
  import mm_pattern_pd_pkg::*;
#(
  parameter int MAX_LOG2 = 10,
  parameter int LOG_W    = $clog2(MAX_LOG2 + 1),
  parameter int SUM_W    = MAX_LOG2 + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  vote_e                   vote,
  input  logic [LOG_W-1:0]        log2_sel,
  output logic                    done,
  output logic signed [SUM_W-1:0] total,
  output logic                    up,
  output logic                    dn
);

  localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  logic [LOG_W-1:0]        m_eff;
  logic [CNT_W:0]          len_full;
  logic [CNT_W:0]          len_m1;
  logic [CNT_W-1:0]        cnt;
  logic                    last;
  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] vval;
  logic signed [SUM_W-1:0] nxt;

  always_comb begin
    m_eff    = (log2_sel > LOG_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : log2_sel;
    len_full = (CNT_W+1)'(1) << m_eff;
    len_m1   = len_full - (CNT_W+1)'(1);
    last     = (cnt == len_m1[CNT_W-1:0]);
  end

  always_comb begin
    unique case (vote)
      VOTE_EARLY: vval = SUM_W'(1);
      VOTE_LATE:  vval = '1;
      default:    vval = '0;
    endcase
    nxt = acc + vval;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      total <= '0;
      up    <= 1'b0;
      dn    <= 1'b0;
    end else begin
      done <= 1'b0;
      up   <= 1'b0;
      dn   <= 1'b0;
      if (step) begin
        if (last) begin
          total <= nxt;
          done  <= 1'b1;
          up    <= (nxt > 0);
          dn    <= (nxt < 0);
          acc   <= '0;
          cnt   <= '0;
        end else begin
          acc <= nxt;
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/mm_pattern_pd.sv
module mm_pattern_pd
  import mm_pattern_pd_pkg::*;
#(
  parameter int MAX_LOG2 = 10,
  parameter int LOG_W    = $clog2(MAX_LOG2 + 1),
  parameter int SUM_W    = MAX_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LOG_W-1:0] blk_log2,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_data,
  input  logic             in_err,
  output logic             sym_early,
  output logic             sym_late,
  output logic             blk_done,
  output logic [SUM_W-1:0] blk_sum,
  output logic             phase_up,
  output logic             phase_dn
);

  logic [2:0]              win;
  logic                    win_err;
  logic                    win_ok;
  vote_e                   vote;
  logic signed [SUM_W-1:0] total;

  assign in_ready = 1'b1;

  pd_window u_window (
    .clk     (clk),
    .rst     (rst),
    .take    (in_valid),
    .dec     (in_data),
    .err     (in_err),
    .win     (win),
    .win_err (win_err),
    .win_ok  (win_ok)
  );

  pd_pattern_vote u_vote (
    .win     (win),
    .win_err (win_err),
    .win_ok  (win_ok),
    .vote    (vote)
  );

  pd_block_acc #(
    .MAX_LOG2 (MAX_LOG2),
    .LOG_W    (LOG_W),
    .SUM_W    (SUM_W)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .step     (win_ok),
    .vote     (vote),
    .log2_sel (blk_log2),
    .done     (blk_done),
    .total    (total),
    .up       (phase_up),
    .dn       (phase_dn)
  );

  assign blk_sum = total;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_early <= 1'b0;
      sym_late  <= 1'b0;
    end else begin
      sym_early <= (vote == VOTE_EARLY);
      sym_late  <= (vote == VOTE_LATE);
    end
  end

endmodule

// File: rtl/mm_pattern_pd_chk.sv
module mm_pattern_pd_chk #(
  parameter int SUM_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             sym_early,
  input logic             sym_late,
  input logic             blk_done,
  input logic [SUM_W-1:0] blk_sum,
  input logic             phase_up,
  input logic             phase_dn
);

  p_updn_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(phase_up && phase_dn));

  p_vote_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(sym_early && sym_late));

  p_up_positive_r8: assert property (@(posedge clk) disable iff (rst)
    phase_up |-> (blk_done && $signed(blk_sum) > 0));

  p_dn_negative_r8: assert property (@(posedge clk) disable iff (rst)
    phase_dn |-> (blk_done && $signed(blk_sum) < 0));

  p_zero_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (blk_done && blk_sum == '0) |-> (!phase_up && !phase_dn));

  p_vote_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (sym_early || sym_late) |-> $past(in_valid));

  p_done_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> $past(in_valid));

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sym_early && !sym_late && !blk_done));

endmodule

bind mm_pattern_pd mm_pattern_pd_chk #(.SUM_W(SUM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .sym_early (sym_early),
  .sym_late  (sym_late),
  .blk_done  (blk_done),
  .blk_sum   (blk_sum),
  .phase_up  (phase_up),
  .phase_dn  (phase_dn)
);

// File: tb/test_mm_pattern_pd.sv
module test_mm_pattern_pd;

  localparam int MAX_LOG2 = 10;
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
  localparam int SUM_W    = MAX_LOG2 + 2;
  localparam int NVEC     = 16;

  // row: [15]valid [14]data [13]err [12]early [11]late [10]done [9]up [8]dn [7:0]sum
  localparam logic [15:0] VEC [NVEC] = '{
    {3'b100, 5'b00000, 8'sd0},
    {3'b111, 5'b00000, 8'sd0},
    {3'b110, 5'b01000, 8'sd0},
    {3'b100, 5'b01000, 8'sd0},
    {3'b011, 5'b00000, 8'sd0},
    {3'b101, 5'b01000, 8'sd0},
    {3'b110, 5'b01101, 8'hFC},
    {3'b111, 5'b10000, 8'sd0},
    {3'b111, 5'b00000, 8'sd0},
    {3'b100, 5'b10000, 8'sd0},
    {3'b111, 5'b00110, 8'h02},
    {3'b111, 5'b01000, 8'sd0},
    {3'b100, 5'b10000, 8'sd0},
    {3'b011, 5'b00000, 8'sd0},
    {3'b110, 5'b00000, 8'sd0},
    {3'b100, 5'b00100, 8'sd0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LOG_W-1:0] blk_log2 = LOG_W'(2);
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_data = 1'b0;
  logic             in_err = 1'b0;
  logic             sym_early;
  logic             sym_late;
  logic             blk_done;
  logic [SUM_W-1:0] blk_sum;
  logic             phase_up;
  logic             phase_dn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mm_pattern_pd #(.MAX_LOG2(MAX_LOG2)) i_mm_pattern_pd (
    .clk       (clk),
    .rst       (rst),
    .blk_log2  (blk_log2),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_err    (in_err),
    .sym_early (sym_early),
    .sym_late  (sym_late),
    .blk_done  (blk_done),
    .blk_sum   (blk_sum),
    .phase_up  (phase_up),
    .phase_dn  (phase_dn)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic d, logic e);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    in_err   = e;
    @(posedge clk);
    #2;
  endtask

  task automatic chk_out(string tag, int e, int l, int dn_, int u, int d, int s, logic sum_care);
    chk({tag, " early"}, int'(sym_early), e);
    chk({tag, " late"},  int'(sym_late),  l);
    chk({tag, " done"},  int'(blk_done),  dn_);
    chk({tag, " up"},    int'(phase_up),  u);
    chk({tag, " dn"},    int'(phase_dn),  d);
    if (sum_care) chk({tag, " sum"}, int'($signed(blk_sum)), s);
  endtask

  task automatic do_reset(logic [LOG_W-1:0] m);
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b0;
    blk_log2 = m;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state, R6 ready always high
    chk_out("R10 reset", 0, 0, 0, 0, 0, 0, 1'b1);
    chk("R6 ready", int'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;

    // table walk, M=2: R1 R2 R3 R4 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] r;
      r = VEC[i];
      step(r[15], r[14], r[13]);
      chk_out($sformatf("R1-table row %0d (R2 R3 R4 R7 R8)", i),
              int'(r[12]), int'(r[11]), int'(r[10]), int'(r[9]), int'(r[8]),
              int'($signed(r[7:0])), r[10]);
    end

    // R9: M=0, every window closes its own block, vote and done coincide
    do_reset(LOG_W'(0));
    step(1'b1, 1'b0, 1'b0);
    chk_out("R10 fill first", 0, 0, 0, 0, 0, 0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk_out("R10 fill second", 0, 0, 0, 0, 0, 0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    chk_out("R9 011 late closes block", 0, 1, 1, 0, 1, -1, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    chk_out("R9 110 late closes block", 0, 1, 1, 0, 1, -1, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    chk_out("R8 101 zero block", 0, 0, 1, 0, 0, 0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk_out("R9 011 early closes block", 1, 0, 1, 1, 0, 1, 1'b1);

    // R10: reset mid-stream, history must not leak into new windows
    do_reset(LOG_W'(0));
    step(1'b1, 1'b1, 1'b1);
    chk_out("R10 after reset sym1", 0, 0, 0, 0, 0, 0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk_out("R10 after reset sym2", 0, 0, 0, 0, 0, 0, 1'b0);

    // R7: M=3, eight windows per block, one late vote then seven quiet
    do_reset(LOG_W'(3));
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b1, 1'b1);
      if (k < 7)
        chk($sformatf("R7 no done at window %0d", k), int'(blk_done), 0);
      else
        chk_out("R7 block of eight", 0, 0, 1, 0, 1, -1, 1'b1);
    end

    // R7: M above MAX_LOG2 clamps; short run must not close a block
    do_reset(LOG_W'(15));
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 1'b0);
    chk("R7 clamped long block", int'(blk_done), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule